// File: doc/BRIEF.md
# Programmable-Rate Time-of-Day Counter with Pulse-Aligned Loading

This block keeps the time of day as a pair of counters: a sub-second tick count that advances once per clock and a whole-seconds count. The tick count wraps at a rate that software programs. Each wrap advances the seconds count by one.

Software writes a new seconds value and a new tick value into staging registers. It then arms a load by writing the mode register. In immediate mode the staged time replaces the running time on the next clock. In deferred mode the load waits for the chosen edge of an external once-per-second pulse. That pulse is first brought into the clock domain through a synchroniser.

On every chosen pulse edge the block also records the running time into a pair of capture outputs. Software can read these to learn when the pulse arrived. The bus fabric and the readback selection sit outside this block.

Top module: `pps_time_counter`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `time_secs`, `time_ticks`, `pps_secs` and `pps_ticks` are all zero. The reset state is: rate register = `DEFAULT_RATE`, mode bit = 0, edge select = 0, no load armed.
- R2: With no load applied and no wrap, `time_ticks` grows by exactly one on every clock and `time_secs` holds.
- R3: When `time_ticks + 1` is at least the rate register (unsigned), the next clock sets `time_ticks` to 0 and adds one to `time_secs`.
- R4: The configuration port decodes word addresses as follows: 0 = staged seconds, 1 = staged ticks, 2 = edge select (bit 0), 3 = mode (bit 0), 4 = rate. A write to address 4 moves the wrap point from the next clock on.
- R5: A write to address 3 with bit 0 = 1 arms a load. On the clock after the write, `time_secs` and `time_ticks` become exactly the staged values.
- R6: A write to address 3 with bit 0 = 0 arms a deferred load. The counter keeps running unchanged until a selected pulse edge, and on that edge it takes the staged values.
- R7: `pps_in` passes through two synchroniser flops and one history flop. A selected transition on `pps_in` therefore takes effect on the third rising clock edge that samples the new level.
- R8: Edge select bit 0 = 1 selects the rising edge of `pps_in`, and 0 selects the falling edge. The other edge neither loads nor captures.
- R9: On every selected pulse edge, `pps_secs` and `pps_ticks` take the values that `time_secs` and `time_ticks` held just before that edge.
- R10: An armed load is applied once and then disarmed. Later pulse edges capture the time but do not reload the counter until a new write to address 3.
- R11: Writes to the staging addresses (0 and 1) alone do not change the running time, and writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | TW | Configuration write data |
| pps_in | input | 1 | Asynchronous once-per-second pulse |
| time_secs | output | TW | Running seconds count |
| time_ticks | output | TW | Running tick count within the second |
| pps_secs | output | TW | Seconds captured at the last selected pulse edge |
| pps_ticks | output | TW | Ticks captured at the last selected pulse edge |

## Verification
The counter is run free in several ways: at the default rate, at a short programmed rate so that wraps come often, and after the rate is cut below the present tick count, which tells a greater-or-equal wrap test apart from an equality test. Immediate loads are set against deferred loads. A pulse of each polarity is applied under each edge setting, which shows whether the wrong edge is ignored and whether the three-flop delay is exact. Unarmed staging writes and repeated pulses after a load check that nothing reloads without a fresh arm, while the capture outputs still follow every selected edge.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_SECS  = 3'd0;
  localparam logic [AW-1:0] A_TICKS = 3'd1;
  localparam logic [AW-1:0] A_EDGE  = 3'd2;
  localparam logic [AW-1:0] A_MODE  = 3'd3;
  localparam logic [AW-1:0] A_RATE  = 3'd4;
endpackage

// File: rtl/ptc_pps_edge.sv
module ptc_pps_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_in,
  input  logic rise_sel,
  output logic hit
);
  localparam int LAST = STAGES - 1;

  // chain[0..LAST] synchronise, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST:0], pps_in};
  end

  logic now_lvl, old_lvl;
  assign now_lvl = chain[LAST];
  assign old_lvl = chain[STAGES];

  always_comb begin
    if (rise_sel) hit = now_lvl & ~old_lvl;
    else          hit = ~now_lvl & old_lvl;
  end
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int          TW           = 32,
  parameter logic [TW-1:0] DEFAULT_RATE = 32'd100_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          hit,
  output logic [TW-1:0] stg_secs,
  output logic [TW-1:0] stg_ticks,
  output logic [TW-1:0] rate,
  output logic          rise_sel,
  output logic          pending,
  output logic          load_go
);
  logic imm_mode;
  logic arm_wr;

  assign arm_wr  = cfg_we && (cfg_addr == A_MODE);
  assign load_go = pending && (imm_mode || hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_secs  <= '0;
      stg_ticks <= '0;
      rate      <= DEFAULT_RATE;
      rise_sel  <= 1'b0;
      imm_mode  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_SECS:  stg_secs  <= cfg_wdata;
        A_TICKS: stg_ticks <= cfg_wdata;
        A_EDGE:  rise_sel  <= cfg_wdata[0];
        A_MODE:  imm_mode  <= cfg_wdata[0];
        A_RATE:  rate      <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (arm_wr)  pending <= 1'b1;
    else if (load_go) pending <= 1'b0;
  end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_go,
  input  logic          hit,
  input  logic [TW-1:0] stg_secs,
  input  logic [TW-1:0] stg_ticks,
  input  logic [TW-1:0] rate,
  output logic [TW-1:0] secs,
  output logic [TW-1:0] ticks,
  output logic [TW-1:0] cap_secs,
  output logic [TW-1:0] cap_ticks
);
  localparam int XW = TW + 1;

  logic [XW-1:0] ticks_nx;
  logic          wrap;

  assign ticks_nx = {1'b0, ticks} + XW'(1);
  assign wrap     = ticks_nx >= {1'b0, rate};

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      ticks <= '0;
    end else if (load_go) begin
      secs  <= stg_secs;
      ticks <= stg_ticks;
    end else if (wrap) begin
      secs  <= secs + TW'(1);
      ticks <= '0;
    end else begin
      ticks <= ticks_nx[TW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_secs  <= '0;
      cap_ticks <= '0;
    end else if (hit) begin
      cap_secs  <= secs;
      cap_ticks <= ticks;
    end
  end
endmodule

// File: rtl/pps_time_counter.sv
module pps_time_counter
  import ptc_pkg::*;
#(
  parameter int            TW           = 32,
  parameter int            SYNC_STAGES  = 2,
  parameter logic [TW-1:0] DEFAULT_RATE = 32'd100_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          pps_in,
  output logic [TW-1:0] time_secs,
  output logic [TW-1:0] time_ticks,
  output logic [TW-1:0] pps_secs,
  output logic [TW-1:0] pps_ticks
);
  logic          hit, rise_sel, pending, load_go;
  logic [TW-1:0] stg_secs, stg_ticks, rate;

  ptc_pps_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pps_in(pps_in), .rise_sel(rise_sel), .hit(hit)
  );

  ptc_regs #(.TW(TW), .DEFAULT_RATE(DEFAULT_RATE)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hit(hit), .stg_secs(stg_secs),
    .stg_ticks(stg_ticks), .rate(rate), .rise_sel(rise_sel),
    .pending(pending), .load_go(load_go)
  );

  ptc_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst(rst), .load_go(load_go), .hit(hit),
    .stg_secs(stg_secs), .stg_ticks(stg_ticks), .rate(rate),
    .secs(time_secs), .ticks(time_ticks),
    .cap_secs(pps_secs), .cap_ticks(pps_ticks)
  );
endmodule

// File: rtl/pps_time_counter_chk.sv
module pps_time_counter_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [TW-1:0] time_secs,
  input logic [TW-1:0] time_ticks,
  input logic [TW-1:0] pps_secs,
  input logic [TW-1:0] pps_ticks,
  input logic [TW-1:0] stg_secs,
  input logic [TW-1:0] stg_ticks,
  input logic [TW-1:0] rate,
  input logic          hit,
  input logic          load_go,
  input logic          pending
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (time_secs == '0 && time_ticks == '0 && pps_secs == '0));

  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_go) &&
     ({1'b0, $past(time_ticks)} + 1'b1) < {1'b0, $past(rate)})
    |-> (time_ticks == $past(time_ticks) + 1'b1 && time_secs == $past(time_secs)));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_go) &&
     ({1'b0, $past(time_ticks)} + 1'b1) >= {1'b0, $past(rate)})
    |-> (time_ticks == '0 && time_secs == $past(time_secs) + 1'b1));

  a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_go))
    |-> (time_secs == $past(stg_secs) && time_ticks == $past(stg_ticks)));

  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit))
    |-> (pps_secs == $past(time_secs) && pps_ticks == $past(time_ticks)));

  a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_go) && !$past(cfg_we && cfg_addr == 3'd3))
    |-> !pending);
endmodule

bind pps_time_counter pps_time_counter_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .time_secs(time_secs), .time_ticks(time_ticks),
  .pps_secs(pps_secs), .pps_ticks(pps_ticks),
  .stg_secs(stg_secs), .stg_ticks(stg_ticks), .rate(rate),
  .hit(hit), .load_go(load_go), .pending(pending)
);

// File: tb/sim_pps_time_counter.sv
`timescale 1ns/1ps
module sim_pps_time_counter;
  localparam int TW = 32;
  localparam logic [TW-1:0] DEF_RATE = 32'd100_000_000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          pps_in = 1'b0;
  logic [TW-1:0] time_secs, time_ticks, pps_secs, pps_ticks;

  pps_time_counter #(.TW(TW), .DEFAULT_RATE(DEF_RATE)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pps_in(pps_in),
    .time_secs(time_secs), .time_ticks(time_ticks),
    .pps_secs(pps_secs), .pps_ticks(pps_ticks)
  );

  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  string req   = "R1";

  // behavioural reference
  longint m_secs, m_ticks, m_psecs, m_pticks, m_ss, m_st, m_rate;
  bit     m_rise, m_imm, m_pend;
  bit     q1, q2, q3;

  task automatic chk(input string r, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, go;
    longint nt;
    if (rst) begin
      m_secs = 0; m_ticks = 0; m_psecs = 0; m_pticks = 0;
      m_ss = 0; m_st = 0; m_rate = DEF_RATE;
      m_rise = 0; m_imm = 0; m_pend = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      hit = m_rise ? (q2 && !q3) : (!q2 && q3);
      go  = m_pend && (m_imm || hit);
      if (hit) begin m_psecs = m_secs; m_pticks = m_ticks; end
      nt = m_ticks + 1;
      if (go) begin m_secs = m_ss; m_ticks = m_st; end
      else if (nt >= m_rate) begin m_ticks = 0; m_secs = (m_secs + 1) & 64'hFFFF_FFFF; end
      else m_ticks = nt;
      if (cfg_we && cfg_addr == 3) m_pend = 1;
      else if (go) m_pend = 0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_ss   = cfg_wdata;
          3'd1: m_st   = cfg_wdata;
          3'd2: m_rise = cfg_wdata[0];
          3'd3: m_imm  = cfg_wdata[0];
          3'd4: m_rate = cfg_wdata;
          default: ;
        endcase
      end
      q3 = q2; q2 = q1; q1 = pps_in;
    end
    #2;
    chk(req, time_secs,  m_secs,   "time_secs");
    chk(req, time_ticks, m_ticks,  "time_ticks");
    chk(req, pps_secs,   m_psecs,  "pps_secs");
    chk(req, pps_ticks,  m_pticks, "pps_ticks");
  end

  task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pps(input logic v);
    @(negedge clk); pps_in = v;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    longint snap;
    req = "R1";
    idle(4);
    chk("R1", time_secs, 0, "secs in reset");
    chk("R1", time_ticks, 0, "ticks in reset");
    rst = 1'b0;
    idle(1);
    chk("R1", time_ticks, 1, "ticks one clock after reset");

    req = "R2";
    idle(20);
    chk("R2", time_ticks, 21, "free-run ticks");

    req = "R4";
    wr(3'd4, 32'd10);
    req = "R3";
    idle(35);

    req = "R5";
    wr(3'd0, 32'd100);
    wr(3'd1, 32'd5);
    wr(3'd3, 32'd1);
    // write edge passed; load lands on the next edge
    @(posedge clk); #3;
    chk("R5", time_secs, 100, "immediate load secs");
    chk("R5", time_ticks, 5, "immediate load ticks");

    req = "R11";
    wr(3'd0, 32'd7);
    wr(3'd1, 32'd3);
    wr(3'd5, 32'd1);
    wr(3'd6, 32'd0);
    wr(3'd7, 32'hFFFF);
    idle(12);
    chk("R11", (time_secs == 7) ? 1 : 0, 0, "staging alone reloads");

    req = "R6";
    wr(3'd0, 32'd500);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    idle(8);
    chk("R6", (time_secs == 500) ? 1 : 0, 0, "deferred load early");

    req = "R8";
    set_pps(1'b1);          // rising edge, falling selected: ignored
    idle(8);
    chk("R8", (time_secs == 500) ? 1 : 0, 0, "wrong edge loaded");

    req = "R7";
    set_pps(1'b0);          // change before edge E0
    @(posedge clk); @(posedge clk); #3;
    chk("R7", (time_secs == 500) ? 1 : 0, 0, "load before third edge");
    @(posedge clk); #3;
    chk("R7", time_secs, 500, "load on third edge secs");
    chk("R7", time_ticks, 2, "load on third edge ticks");

    req = "R9";
    idle(15);
    set_pps(1'b1);
    idle(6);
    set_pps(1'b0);
    idle(6);

    req = "R10";
    snap = pps_secs;
    idle(10);
    set_pps(1'b1);
    idle(4);
    set_pps(1'b0);
    idle(6);
    chk("R10", (time_secs == 500) ? 1 : 0, 0, "reload without arm");

    req = "R8";
    wr(3'd2, 32'd1);
    wr(3'd0, 32'd900);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'd0);
    idle(5);
    set_pps(1'b1);
    idle(4);
    chk("R8", time_secs, 900, "rising edge load");
    set_pps(1'b0);          // falling now ignored
    idle(6);

    req = "R3";
    idle(3);
    wr(3'd4, 32'd2);        // cut rate under present ticks
    idle(10);
    wr(3'd4, 32'd1);
    idle(6);
    wr(3'd4, 32'd0);
    idle(6);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule